// File: doc/BRIEF.md
# Serial Receive Holding Buffer

This block sits between a serial deserializer and a register read interface. The deserializer delivers each completed character as nine data bits and a framing-error bit. It also sends a one-cycle pulse whenever it sees a new start bit. The buffer keeps every character together with its own status bits, so that a reader always sees the status that belongs to the character at the head.

Storage is a small circular FIFO of two slots. The deserializer's shift register serves as a third holding level. A character that completes while both slots are taken is parked in that holding stage. It moves into the FIFO on the clock after a read frees a slot. An overrun is declared only when a new start bit arrives while both slots and the holding stage are all full. The parked character is then dropped, and the next character that enters the FIFO carries the overrun mark.

The reader samples the head status first and the head data after it. It then pulses the pop strobe once for each character it takes.

Top module: `serial_rx_buffer`

## Requirements
- R1: While reset is held and after it is released, `rx_avail` is 0 and `head_data`, `head_ferr` and `head_ovr` are all 0, even if characters had been stored before the reset.
- R2: Characters leave in arrival order. With two slots used, `head_*` shows the older character until it is popped.
- R3: The ninth data bit (`head_data[8]`) and the framing-error bit are stored with each character. After a pop, `head_ferr` shows the status of the new head entry and never the status of the entry just removed.
- R4: A pop strobe while the FIFO is empty has no effect. `rx_avail` stays 0, and the next character written appears at the head.
- R5: A character that completes while both slots are full is kept in the holding stage and is not lost. It enters the FIFO one clock after a pop frees a slot.
- R6: A start-bit pulse while the FIFO is full but the holding stage is empty raises no overrun. Later characters carry `head_ovr` = 0.
- R7: A start-bit pulse while both slots and the holding stage are full discards the held character. The next character written into the FIFO carries `head_ovr` = 1, and characters after it carry 0.
- R8: `rx_avail` is 1 exactly when at least one character is in the FIFO. A character parked only in the holding stage does not count.
- R9: A character accepted into a FIFO with a free slot, with the holding stage empty, is visible at the head output on the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle pulse: a completed character is on `frame_data`/`frame_ferr` |
| frame_data | input | 9 | Received character, bit 8 is the ninth data bit |
| frame_ferr | input | 1 | Framing error seen on this character |
| start_seen | input | 1 | One-cycle pulse: deserializer detected a new start bit |
| rd_pop | input | 1 | Read strobe, removes the head entry |
| rx_avail | output | 1 | FIFO holds at least one character |
| head_data | output | 9 | Data of the head entry |
| head_ferr | output | 1 | Framing-error status of the head entry |
| head_ovr | output | 1 | Overrun status of the head entry |

## Verification
The main function is driven with several patterns: single characters, two-character bursts that fill the FIFO, three-character bursts that reach the holding stage, and bursts followed by a start-bit pulse. Each pattern is mixed with pops at different fill levels. The bursts with alternating error bits and ninth bits show whether status travels with its own character or leaks across entries. A start pulse against a full FIFO with the holding stage empty, set beside the same pulse with the holding stage occupied, shows that overrun is not raised too early. Pops on an empty FIFO followed by fresh writes show that the pointers stay intact.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int RXB_DATA_W = 9;

    // One stored character with the status that travels alongside it
    typedef struct packed {
        logic [RXB_DATA_W-1:0] data;
        logic                  ferr;
        logic                  ovr;
    } rxb_entry_t;

    // Character as delivered by the deserializer (no overrun mark yet)
    typedef struct packed {
        logic [RXB_DATA_W-1:0] data;
        logic                  ferr;
    } rxb_frame_t;

endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  rxb_entry_t push_entry,
    input  logic       pop,
    output rxb_entry_t head,
    output logic       full,
    output logic       empty
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PTR_W = IDX_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    typedef struct packed {
        rxb_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       wr_ptr;
        logic [PTR_W-1:0]       rd_ptr;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [PTR_W-1:0] fill_q;

    assign fill_q = st_q.wr_ptr - st_q.rd_ptr;
    assign full   = (fill_q == DEPTH_P);
    assign empty  = (fill_q == '0);
    assign head   = st_q.mem[st_q.rd_ptr[IDX_W-1:0]];

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.mem[st_q.wr_ptr[IDX_W-1:0]] = push_entry;
            st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
        end
        if (pop && !empty) begin
            st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The holding stage must never offer a character to a full FIFO
    assert_push_has_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // Pop on empty leaves the FIFO empty
    assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    // A push into a non-full FIFO makes it non-empty
    assert_push_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> !empty);

endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
    import rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_valid,
    input  rxb_frame_t frame_in,
    input  logic       start_seen,
    input  logic       fifo_full,
    output logic       push,
    output rxb_entry_t push_entry,
    output logic       hold_valid
);

    typedef struct packed {
        logic       hold_valid;
        rxb_frame_t hold;
        logic       pend_ovr;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        ovr_event;
    logic        hv_eff;

    assign hold_valid = st_q.hold_valid;

    always_comb begin
        st_d       = st_q;
        push       = 1'b0;
        push_entry = '0;
        ovr_event  = 1'b0;
        hv_eff     = st_q.hold_valid;

        // New start bit while every level is occupied: held character is lost
        if (start_seen && st_q.hold_valid && fifo_full) begin
            ovr_event       = 1'b1;
            hv_eff          = 1'b0;
            st_d.hold_valid = 1'b0;
        end

        // Drain the holding stage as soon as a slot is free
        if (hv_eff && !fifo_full) begin
            push            = 1'b1;
            push_entry.data = st_q.hold.data;
            push_entry.ferr = st_q.hold.ferr;
            push_entry.ovr  = st_q.pend_ovr;
            st_d.hold_valid = 1'b0;
            hv_eff          = 1'b0;
        end

        if (frame_valid) begin
            if (hv_eff) begin
                // Shift register overwritten without a drain: also an overrun
                ovr_event = 1'b1;
                st_d.hold = frame_in;
            end else if (!push && !fifo_full) begin
                push            = 1'b1;
                push_entry.data = frame_in.data;
                push_entry.ferr = frame_in.ferr;
                push_entry.ovr  = st_q.pend_ovr;
            end else begin
                st_d.hold       = frame_in;
                st_d.hold_valid = 1'b1;
            end
        end

        st_d.pend_ovr = (st_q.pend_ovr && !push) || ovr_event;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A parked character leaves as soon as a slot is free
    assert_drain_when_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold_valid && !fifo_full) |-> push);

    // Overrun empties the holding stage
    assert_overrun_discards_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && st_q.hold_valid && fifo_full && !frame_valid) |=> !st_q.hold_valid);

    // Start bit with a free holding level raises no overrun
    assert_no_early_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && !st_q.hold_valid && !st_q.pend_ovr && !frame_valid) |=> !st_q.pend_ovr);

    // A pending overrun mark is consumed by the next pushed character
    assert_ovr_mark_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.pend_ovr) |-> push_entry.ovr);

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_valid,
    input  logic [RXB_DATA_W-1:0] frame_data,
    input  logic                  frame_ferr,
    input  logic                  start_seen,
    input  logic                  rd_pop,
    output logic                  rx_avail,
    output logic [RXB_DATA_W-1:0] head_data,
    output logic                  head_ferr,
    output logic                  head_ovr
);

    rxb_frame_t frame_in;
    rxb_entry_t push_entry;
    rxb_entry_t head;
    logic       push;
    logic       fifo_full;
    logic       fifo_empty;
    logic       hold_valid;

    assign frame_in.data = frame_data;
    assign frame_in.ferr = frame_ferr;

    rxb_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_valid(frame_valid),
        .frame_in   (frame_in),
        .start_seen (start_seen),
        .fifo_full  (fifo_full),
        .push       (push),
        .push_entry (push_entry),
        .hold_valid (hold_valid)
    );

    rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_entry(push_entry),
        .pop       (rd_pop),
        .head      (head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    assign rx_avail  = !fifo_empty;
    assign head_data = head.data;
    assign head_ferr = head.ferr;
    assign head_ovr  = head.ovr;

    // Direct write is visible on the next cycle
    assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !fifo_full && !hold_valid && !start_seen) |=> rx_avail);

    // Holding stage is only in use while the FIFO is full or just freed
    assert_hold_implies_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid |-> rx_avail);

endmodule

// File: tb/serial_rx_buffer_tb.sv
module serial_rx_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 27;

    // Vector fields: req[3:0], op[1:0], din[8:0], fin, exp_avail, chk, exp_data[8:0], exp_ferr, exp_ovr
    // op: 0 idle, 1 frame, 2 pop, 3 start pulse
    localparam logic [28:0] VEC [NVEC] = '{
        {4'd9, 2'd1, 9'h1A5, 1'b0, 1'b1, 1'b1, 9'h1A5, 1'b0, 1'b0}, // R9 first write visible
        {4'd2, 2'd1, 9'h03C, 1'b1, 1'b1, 1'b1, 9'h1A5, 1'b0, 1'b0}, // R2 older stays at head
        {4'd3, 2'd2, 9'h000, 1'b0, 1'b1, 1'b1, 9'h03C, 1'b1, 1'b0}, // R3 status follows head
        {4'd8, 2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0}, // R8 empty again
        {4'd4, 2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0}, // R4 pop on empty
        {4'd4, 2'd1, 9'h055, 1'b0, 1'b1, 1'b1, 9'h055, 1'b0, 1'b0}, // R4 pointers intact
        {4'd8, 2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0}, // R8
        {4'd3, 2'd1, 9'h101, 1'b0, 1'b1, 1'b1, 9'h101, 1'b0, 1'b0}, // R3 ninth bit set
        {4'd2, 2'd1, 9'h002, 1'b1, 1'b1, 1'b1, 9'h101, 1'b0, 1'b0}, // R2 full
        {4'd6, 2'd3, 9'h000, 1'b0, 1'b1, 1'b1, 9'h101, 1'b0, 1'b0}, // R6 start with free hold
        {4'd5, 2'd1, 9'h0F3, 1'b0, 1'b1, 1'b1, 9'h101, 1'b0, 1'b0}, // R5 third char parked
        {4'd5, 2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 9'h101, 1'b0, 1'b0}, // R5 head unchanged
        {4'd3, 2'd2, 9'h000, 1'b0, 1'b1, 1'b1, 9'h002, 1'b1, 1'b0}, // R3 next status
        {4'd5, 2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 9'h002, 1'b1, 1'b0}, // R5 drain cycle
        {4'd6, 2'd2, 9'h000, 1'b0, 1'b1, 1'b1, 9'h0F3, 1'b0, 1'b0}, // R6 parked char, no ovr
        {4'd8, 2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0}, // R8
        {4'd9, 2'd1, 9'h011, 1'b0, 1'b1, 1'b1, 9'h011, 1'b0, 1'b0}, // R9
        {4'd2, 2'd1, 9'h022, 1'b0, 1'b1, 1'b1, 9'h011, 1'b0, 1'b0}, // R2
        {4'd5, 2'd1, 9'h033, 1'b1, 1'b1, 1'b1, 9'h011, 1'b0, 1'b0}, // R5 parked
        {4'd7, 2'd3, 9'h000, 1'b0, 1'b1, 1'b1, 9'h011, 1'b0, 1'b0}, // R7 overrun event
        {4'd7, 2'd1, 9'h044, 1'b0, 1'b1, 1'b1, 9'h011, 1'b0, 1'b0}, // R7 next char parked
        {4'd7, 2'd2, 9'h000, 1'b0, 1'b1, 1'b1, 9'h022, 1'b0, 1'b0}, // R7 old entries clean
        {4'd5, 2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 9'h022, 1'b0, 1'b0}, // R5 drain
        {4'd7, 2'd2, 9'h000, 1'b0, 1'b1, 1'b1, 9'h044, 1'b0, 1'b1}, // R7 ovr mark, 033 dropped
        {4'd7, 2'd1, 9'h1C8, 1'b1, 1'b1, 1'b1, 9'h044, 1'b0, 1'b1}, // R7
        {4'd7, 2'd2, 9'h000, 1'b0, 1'b1, 1'b1, 9'h1C8, 1'b1, 1'b0}, // R7 mark used once
        {4'd8, 2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0}  // R8
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0;
    logic [8:0] frame_data = '0;
    logic       frame_ferr = 1'b0;
    logic       start_seen = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rx_avail;
    logic [8:0] head_data;
    logic       head_ferr;
    logic       head_ovr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_buffer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_valid(frame_valid),
        .frame_data (frame_data),
        .frame_ferr (frame_ferr),
        .start_seen (start_seen),
        .rd_pop     (rd_pop),
        .rx_avail   (rx_avail),
        .head_data  (head_data),
        .head_ferr  (head_ferr),
        .head_ovr   (head_ovr)
    );

    task automatic check(input int req, input logic chk_data, input logic e_av,
                         input logic [8:0] e_d, input logic e_f, input logic e_o);
        logic bad;
        checks++;
        bad = (rx_avail !== e_av);
        if (chk_data) bad = bad || (head_data !== e_d) || (head_ferr !== e_f) || (head_ovr !== e_o);
        if (bad) begin
            fails++;
            $display("FAIL R%0d: got avail=%b data=%h ferr=%b ovr=%b, expected avail=%b data=%h ferr=%b ovr=%b",
                     req, rx_avail, head_data, head_ferr, head_ovr, e_av, e_d, e_f, e_o);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [8:0] d, input logic f);
        @(negedge clk);
        frame_valid = (op == 2'd1);
        frame_data  = d;
        frame_ferr  = f;
        rd_pop      = (op == 2'd2);
        start_seen  = (op == 2'd3);
        @(negedge clk);
        frame_valid = 1'b0;
        rd_pop      = 1'b0;
        start_seen  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, 1'b1, 1'b0, 9'h000, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b1, 1'b0, 9'h000, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            logic [28:0] v;
            v = VEC[i];
            step(v[24:23], v[22:14], v[13]);
            check(int'(v[28:25]), v[11], v[12], v[10:2], v[1], v[0]);
        end

        // R1: reset clears stored characters and status
        step(2'd1, 9'h1FF, 1'b1);
        step(2'd1, 9'h0AA, 1'b1);
        step(2'd1, 9'h0BB, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b1, 1'b0, 9'h000, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(1, 1'b1, 1'b0, 9'h000, 1'b0, 1'b0); // R1 parked char also gone
        step(2'd1, 9'h077, 1'b0);
        check(9, 1'b1, 1'b1, 9'h077, 1'b0, 1'b0); // R9 after reset, no stale ovr

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule